// File: doc/BRIEF.md
# Modem Status Tracker with Loopback

This block keeps the modem status byte of a 16550-style serial port. It watches the four modem input lines (carrier detect, ring, data set ready, clear to send), passes them through a two-flop synchroniser, and holds their last registered level. It also holds four sticky change flags. Software reads the byte through a read strobe, and the read clears the change flags.

When the loopback bit of the modem control byte is set, the read value shows the control outputs fed back onto the status positions instead of the pins. A single `any_delta` output, the OR of the change flags, goes to the interrupt encoder.

The modem control register lives outside this block. Its five low bits are wired in on `mcr_bits`: bit 4 is loopback enable, bit 3 is OUT2, bit 2 is OUT1, bit 1 is RTS and bit 0 is DTR.

Top module: `modem_status_unit`

## Requirements
- R1: After reset the read value is 0xB0 (carrier detect, data set ready and clear to send high, ring low, no change flags) and `any_delta` is 0.
- R2: With loopback off, `rd_data` shows the registered line levels and the flags: bit 7 carrier detect, bit 6 ring, bit 5 data set ready, bit 4 clear to send, bit 3 carrier-detect change, bit 2 ring trailing edge, bit 1 data-set-ready change, bit 0 clear-to-send change.
- R3: A level change on a modem pin first shows in `rd_data` after the third rising clock edge that follows it: two synchroniser stages, then the status register. The change flag is set at that same edge.
- R4: The change flags for carrier detect, data set ready and clear to send are set on a change in either direction. Once set, a flag stays set until it is cleared.
- R5: The ring flag (bit 2) is set only when the registered ring level goes from 1 to 0. A change from 0 to 1 leaves it unchanged.
- R6: With loopback off, a cycle with `rd_stb` high returns the current byte and clears bits 3:0 at the next edge. A line change detected at that same edge still sets its flag.
- R7: With `mcr_bits[4]` high, `rd_data[7:4]` is {OUT2, OUT1, DTR, RTS}, taken from `mcr_bits[3]`, `mcr_bits[2]`, `mcr_bits[0]` and `mcr_bits[1]`, and `rd_data[3:0]` is 0.
- R8: In loopback a read strobe does not clear the change flags. The pins keep being tracked, so the flags and levels are visible once loopback is left.
- R9: `any_delta` is the OR of the four change flags, whatever the loopback setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_cts | input | 1 | Clear-to-send line, asynchronous |
| pin_dsr | input | 1 | Data-set-ready line, asynchronous |
| pin_dcd | input | 1 | Carrier-detect line, asynchronous |
| pin_ri | input | 1 | Ring line, asynchronous |
| mcr_bits | input | 5 | Modem control bits: [4] loopback, [3] OUT2, [2] OUT1, [1] RTS, [0] DTR |
| rd_stb | input | 1 | One-cycle read of the status byte |
| rd_data | output | 8 | Status byte read value |
| any_delta | output | 1 | OR of the change flags |

## Verification
The assertions assume that `rd_stb` and `mcr_bits` are synchronous to `clk` and only change between edges. They also assume that the pins hold their reset levels while reset is applied, so the synchroniser and status register start out equal. The bench drives every input on the falling edge and holds the pins at 1011 during reset. Pin changes are kept sparse, so single changes and back-to-back changes both reach the tracker, and loopback is switched on and off in runs.

// File: rtl/msr_pkg.sv
// Package: shared types and constants for the modem status tracker.
// Assumes the line vector order {dcd, ri, dsr, cts} from MSB to LSB.
package msr_pkg;

    localparam int NUM_LINES   = 4;
    localparam int SYNC_DEPTH  = 2;

    // Bit positions inside a line vector
    localparam int IDX_DCD = 3;
    localparam int IDX_RI  = 2;
    localparam int IDX_DSR = 1;
    localparam int IDX_CTS = 0;

    // Modem control bit positions
    localparam int MC_LOOP = 4;
    localparam int MC_OUT2 = 3;
    localparam int MC_OUT1 = 2;
    localparam int MC_RTS  = 1;
    localparam int MC_DTR  = 0;
    localparam int MC_WIDTH = 5;

    // Reset levels: carrier, data set ready and clear to send high, ring low
    localparam logic [NUM_LINES-1:0] LINES_RESET = 4'b1011;

    typedef struct packed {
        logic dcd;
        logic ri;
        logic dsr;
        logic cts;
    } line_t;

endpackage

// File: rtl/msr_sync.sv
// Module: multi-stage synchroniser for asynchronous level inputs.
// Assumes the inputs are slow levels; each bit is synchronised on its own.
// Reset loads RST_VAL into every stage so no change is seen after reset.
module msr_sync #(
    parameter int              WIDTH   = 4,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // First stage: capture the raw asynchronous level
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= async_in;
                end
            end else begin : g_next
                // Later stages: shift the previous stage on
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[g] <= RST_VAL;
                    else        stage_q[g] <= stage_q[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/msr_track.sv
// Module: registered line levels and sticky change flags.
// Assumes samp_in is already synchronous. The ring flag marks only a
// 1-to-0 step. A clear request zeroes the flags except for a change that
// is detected in the same cycle.
module msr_track
    import msr_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  line_t samp_in,
    input  logic  clr_req,
    output line_t stat_q,
    output line_t delta_q
);

    line_t delta_set;
    line_t delta_base;

    // Detect a change between the registered level and the new sample
    always_comb begin
        delta_set.dcd = stat_q.dcd ^ samp_in.dcd;
        delta_set.ri  = stat_q.ri & ~samp_in.ri;
        delta_set.dsr = stat_q.dsr ^ samp_in.dsr;
        delta_set.cts = stat_q.cts ^ samp_in.cts;
    end

    // Flags that survive this cycle before new changes are merged
    always_comb begin
        delta_base = clr_req ? line_t'('0) : delta_q;
    end

    // Register the levels and the merged flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q  <= line_t'(LINES_RESET);
            delta_q <= line_t'('0);
        end else begin
            stat_q  <= samp_in;
            delta_q <= delta_base | delta_set;
        end
    end

    // R4: without a clear, no set flag drops
    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_req |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

    // R5: the ring flag rises only on a registered 1-to-0 ring step
    a_r5_ring_fall_only: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(delta_q.ri) |-> ($past(stat_q.ri) && !stat_q.ri));

endmodule

// File: rtl/msr_loop_map.sv
// Module: builds the read byte. In loopback the control outputs replace
// the line levels and the low nibble reads as zero.
// Assumes mcr_bits uses the fixed control bit positions from msr_pkg.
module msr_loop_map
    import msr_pkg::*;
(
    input  logic [MC_WIDTH-1:0] mcr_bits,
    input  line_t               stat_in,
    input  line_t               delta_in,
    output logic [7:0]          rd_val
);

    line_t looped;

    // Route control outputs onto the status positions
    always_comb begin
        looped.dcd = mcr_bits[MC_OUT2];
        looped.ri  = mcr_bits[MC_OUT1];
        looped.dsr = mcr_bits[MC_DTR];
        looped.cts = mcr_bits[MC_RTS];
    end

    // Choose between loopback and normal read byte
    always_comb begin
        if (mcr_bits[MC_LOOP]) rd_val = {looped, 4'b0000};
        else                   rd_val = {stat_in, delta_in};
    end

endmodule

// File: rtl/modem_status_unit.sv
// Module: modem status byte of a 16550-style port, with loopback read.
// Assumes rd_stb and mcr_bits are synchronous to clk. Pins are
// asynchronous and pass through a SYNC_DEPTH-stage synchroniser.
module modem_status_unit
    import msr_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                pin_cts,
    input  logic                pin_dsr,
    input  logic                pin_dcd,
    input  logic                pin_ri,
    input  logic [MC_WIDTH-1:0] mcr_bits,
    input  logic                rd_stb,
    output logic [7:0]          rd_data,
    output logic                any_delta
);

    logic [NUM_LINES-1:0] pins_raw;
    logic [NUM_LINES-1:0] pins_sync;
    line_t                samp;
    line_t                stat_q;
    line_t                delta_q;
    logic                 loop_en;
    logic                 clr_req;

    // Gather pins in line-vector order
    assign pins_raw = {pin_dcd, pin_ri, pin_dsr, pin_cts};
    assign samp     = line_t'(pins_sync);
    assign loop_en  = mcr_bits[MC_LOOP];
    // Only a normal-mode read clears the flags
    assign clr_req  = rd_stb & ~loop_en;

    msr_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_DEPTH),
        .RST_VAL(LINES_RESET)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pins_raw),
        .sync_out(pins_sync)
    );

    msr_track u_track (
        .clk    (clk),
        .rst_n  (rst_n),
        .samp_in(samp),
        .clr_req(clr_req),
        .stat_q (stat_q),
        .delta_q(delta_q)
    );

    msr_loop_map u_map (
        .mcr_bits(mcr_bits),
        .stat_in (stat_q),
        .delta_in(delta_q),
        .rd_val  (rd_data)
    );

    assign any_delta = |delta_q;

    // R3: a synchronised change reaches the status register one edge later
    a_r3_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (samp != stat_q) |=> (stat_q == $past(samp)));

    // R6: a normal read with no pending change leaves all flags clear
    a_r6_clear_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !loop_en && (samp == stat_q)) |=> (any_delta == 1'b0));

    // R7: the loopback read byte has a zero low nibble
    a_r7_loop_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
        loop_en |-> (rd_data[3:0] == 4'b0000));

    // R8: a loopback read drops no flag
    a_r8_loop_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && loop_en) |=> ((delta_q & $past(delta_q)) == $past(delta_q)));

    // R9: in normal mode the interrupt flag agrees with the read low nibble
    a_r9_any_matches: assert property (@(posedge clk) disable iff (!rst_n)
        !loop_en |-> (any_delta == (|rd_data[3:0])));

endmodule

// File: tb/sim_modem_status_unit.sv
`timescale 1ns/1ps
module sim_modem_status_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_cts = 1'b1, pin_dsr = 1'b1, pin_dcd = 1'b1, pin_ri = 1'b0;
    logic [4:0] mcr_bits = 5'b01000;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       any_delta;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    // Bench model state, nibble order {dcd, ri, dsr, cts}
    logic [3:0] m_s1 = 4'b1011, m_s2 = 4'b1011, m_stat = 4'b1011, m_delta = 4'b0000;

    always #4 clk = ~clk;

    modem_status_unit u0 (
        .clk(clk), .rst_n(rst_n),
        .pin_cts(pin_cts), .pin_dsr(pin_dsr), .pin_dcd(pin_dcd), .pin_ri(pin_ri),
        .mcr_bits(mcr_bits), .rd_stb(rd_stb),
        .rd_data(rd_data), .any_delta(any_delta)
    );

    function automatic logic [3:0] chg(input logic [3:0] old_v, input logic [3:0] new_v);
        return {old_v[3] ^ new_v[3], old_v[2] & ~new_v[2], old_v[1] ^ new_v[1], old_v[0] ^ new_v[0]};
    endfunction

    function automatic logic [7:0] exp_read(input logic [4:0] mc, input logic [3:0] st, input logic [3:0] dl);
        if (mc[4]) return {mc[3], mc[2], mc[0], mc[1], 4'b0000};
        return {st, dl};
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] pins_now();
        return {pin_dcd, pin_ri, pin_dsr, pin_cts};
    endfunction

    task automatic set_pins(input logic [3:0] v);
        {pin_dcd, pin_ri, pin_dsr, pin_cts} = v;
    endtask

    // One cycle: inputs already set after a falling edge
    task automatic step(input string req);
        logic [3:0] nd;
        #1;
        check(req, rd_data, exp_read(mcr_bits, m_stat, m_delta));
        check("R9", {7'd0, any_delta}, {7'd0, |m_delta});
        @(posedge clk);
        nd = (rd_stb && !mcr_bits[4]) ? 4'b0000 : m_delta;
        m_delta = nd | chg(m_stat, m_s2);
        m_stat  = m_s2;
        m_s2    = m_s1;
        m_s1    = pins_now();
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1: reset value
        check("R1", rd_data, 8'hB0);
        check("R1", {7'd0, any_delta}, 8'h00);
        step("R1");

        // R3: clear to send drops, visible after third edge
        set_pins(4'b1010);
        step("R3"); step("R3"); step("R3");
        check("R3", rd_data, 8'hA1);

        // R4: returns high, flag stays set and level follows
        set_pins(4'b1011);
        repeat (4) step("R4");
        check("R4", rd_data, 8'hB1);

        // R6: read clears flags
        rd_stb = 1'b1; step("R6"); rd_stb = 1'b0;
        step("R6");
        check("R6", rd_data, 8'hB0);

        // R5: ring rise does not set the flag, ring fall does
        set_pins(4'b1111);
        repeat (4) step("R5");
        check("R5", rd_data, 8'hF0);
        set_pins(4'b1011);
        repeat (4) step("R5");
        check("R5", rd_data, 8'hB4);
        rd_stb = 1'b1; step("R6"); rd_stb = 1'b0;

        // R6: change detected at the read edge is kept
        set_pins(4'b1001);
        step("R6"); step("R6");
        rd_stb = 1'b1; step("R6"); rd_stb = 1'b0;
        step("R6");
        check("R6", rd_data, 8'h92);

        // R7: loopback mapping, one control bit at a time
        mcr_bits = 5'b11000; step("R7"); check("R7", rd_data, 8'h80);
        mcr_bits = 5'b10100; step("R7"); check("R7", rd_data, 8'h40);
        mcr_bits = 5'b10001; step("R7"); check("R7", rd_data, 8'h20);
        mcr_bits = 5'b10010; step("R7"); check("R7", rd_data, 8'h10);

        // R8: loopback read keeps flags, pins tracked meanwhile
        rd_stb = 1'b1; step("R8"); rd_stb = 1'b0;
        set_pins(4'b0001);
        repeat (4) step("R8");
        mcr_bits = 5'b01000;
        step("R8");
        check("R8", rd_data, 8'h1A);
        rd_stb = 1'b1; step("R6"); rd_stb = 1'b0;

        // Constrained random run
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 8 == 0) set_pins(pins_now() ^ (4'b0001 << ($urandom % 4)));
            if ($urandom % 64 == 0) mcr_bits[4] = ~mcr_bits[4];
            if ($urandom % 16 == 0) mcr_bits[3:0] = 4'($urandom);
            rd_stb = ($urandom % 4 == 0);
            step(mcr_bits[4] ? "R7" : "R2");
        end
        rd_stb = 1'b0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule